// File: doc/BRIEF.md
# Multi-line external edge interrupt controller

This block turns edges on nineteen input lines into latched interrupt requests. Sixteen of the lines come from general-purpose pins. Each of these pin lines picks bit n of one of five 16-pin ports, so any of 80 pins can serve as a source. The other three lines come from dedicated internal event inputs. For each line, software chooses whether a rising edge, a falling edge or both edges set the line's pending flag. The capture path also catches pulses that begin and end between two clock edges.

Pending flags stay set until software writes a one to them. A software-trigger register can set any pending flag directly. A per-line enable acts as the mask: it decides which pending flags reach the per-line request vector and the combined request output. Configuration and readback go through a simple register port with a one-cycle write and a combinational read. The bus protocol wrapper and the processor's interrupt controller sit outside this block.

Top module: `ext_edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and both `irq_vec` and `irq_any` are 0.
- R2: When a line's bit is set in the rising-enable register (address 1), a 0-to-1 change on that line sets its pending bit. The bit is visible on the third rising clock edge after the change, and not before. A 1-to-0 change with only the rising enable set leaves pending at 0.
- R3: When a line's bit is set in the falling-enable register (address 2), a 1-to-0 change on that line sets its pending bit. A 0-to-1 change with only the falling enable set leaves pending at 0.
- R4: When both enables are set for a line, either direction of change sets its pending bit.
- R5: A line with neither enable set never has its pending bit set by activity on that line.
- R6: A pulse whose two transitions both fall between consecutive clock edges still sets the pending bit of an enabled line. This holds for both polarities.
- R7: `irq_vec` equals pending AND the line-enable register (address 0), and `irq_any` is its OR. A disabled line keeps its pending bit, and the request appears as soon as the line is enabled.
- R8: Writing to the pending register (address 3) clears each bit written as 1 and leaves bits written as 0 unchanged. An edge that is detected in the same cycle as the clear keeps the bit set.
- R9: Writing to the software-trigger register (address 4) sets the pending bits written as 1 at that clock edge, whatever the edge configuration. The register always reads 0.
- R10: Pin line n (n < 16) follows port_pins[16*s + n], where s is the 3-bit select field for line n. The field for line n < 8 sits at bits [3n+2:3n] of address 5, and the field for line n >= 8 sits at bits [3(n-8)+2:3(n-8)] of address 6. Select values 5 to 7 hold the line at 0.
- R11: Lines 16, 17 and 18 follow `evt_in[0]`, `evt_in[1]` and `evt_in[2]`.
- R12: The enable, rising, falling, pending and select registers read back their stored values, zero-extended to 32 bits. Line i is bit i in all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | 80 | Five 16-pin ports, port p at bits [16p+15:16p] |
| evt_in | input | 3 | Internal event sources for lines 16 to 18 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_vec | output | 19 | Per-line request, pending AND enable |
| irq_any | output | 1 | OR of all per-line requests |

## Verification
A change on a line takes three rising clock edges to reach the pending bit: two synchronizer stages and then the pending register. The bench changes its inputs at a falling edge. It checks that pending is still clear after the second rising edge and set after the third, and in random rounds it waits four edges before reading. Register writes and software triggers take effect at the single rising edge inside the bench's write task. `irq_vec` and `irq_any` follow pending and the enables in the same cycle, so every read and output sample is taken shortly after a falling edge. The clear-versus-edge case is set up by starting a clear write exactly two falling edges after the line changes, so that the clear lands on the same edge as the detected edge.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int PINS_PER_PORT = 16;
  localparam int NUM_PORTS     = 5;
  localparam int NUM_INT_EVT   = 3;
  localparam int NUM_LINES     = PINS_PER_PORT + NUM_INT_EVT;
  localparam int PIN_BITS      = NUM_PORTS * PINS_PER_PORT;
  localparam int SEL_W         = 3;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 3;
  localparam int SEL_PER_REG   = 8;
  localparam int SEL_REG_BITS  = SEL_PER_REG * SEL_W;
  localparam int NUM_SEL_REGS  = PINS_PER_PORT / SEL_PER_REG;
  localparam int SYNC_STAGES   = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LINE_EN = 3'd0,
    ADDR_RISE    = 3'd1,
    ADDR_FALL    = 3'd2,
    ADDR_PEND    = 3'd3,
    ADDR_SWTRIG  = 3'd4,
    ADDR_SEL_LO  = 3'd5,
    ADDR_SEL_HI  = 3'd6
  } reg_addr_e;

  // Bit n of the selected port; out-of-range selects give a quiet line.
  function automatic logic pick_port_bit(input logic [PIN_BITS-1:0] pins,
                                         input logic [SEL_W-1:0] sel,
                                         input int bitn);
    if (int'(sel) < NUM_PORTS) return pins[int'(sel) * PINS_PER_PORT + bitn];
    return 1'b0;
  endfunction

  // Pending update: clear by write-one, set wins over clear.
  function automatic logic [NUM_LINES-1:0] pend_next(input logic [NUM_LINES-1:0] cur,
                                                     input logic [NUM_LINES-1:0] clr,
                                                     input logic [NUM_LINES-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/ext_irq_line_router.sv
`timescale 1ns/1ps
module ext_irq_line_router
  import ext_irq_pkg::*;
(
  input  logic [PIN_BITS-1:0]            port_pins,
  input  logic [PINS_PER_PORT*SEL_W-1:0] sel_flat,
  input  logic [NUM_INT_EVT-1:0]         evt_in,
  output logic [NUM_LINES-1:0]           lines
);
  for (genvar n = 0; n < PINS_PER_PORT; n++) begin : g_pin
    assign lines[n] = pick_port_bit(port_pins, sel_flat[n*SEL_W +: SEL_W], n);
  end
  for (genvar e = 0; e < NUM_INT_EVT; e++) begin : g_evt
    assign lines[PINS_PER_PORT + e] = evt_in[e];
  end
endmodule

// File: rtl/ext_irq_edge_capture.sv
`timescale 1ns/1ps
module ext_irq_edge_capture
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_en,
  input  logic fall_en,
  output logic hit
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic             rise_tgl, fall_tgl;
  logic [DEPTH-1:0] rise_sync, fall_sync;

  // The line itself clocks these, so pulses shorter than clk are still seen.
  always_ff @(posedge line_in or negedge rst_n)
    if (!rst_n) rise_tgl <= 1'b0;
    else        rise_tgl <= ~rise_tgl;

  always_ff @(negedge line_in or negedge rst_n)
    if (!rst_n) fall_tgl <= 1'b0;
    else        fall_tgl <= ~fall_tgl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_sync <= '0;
      fall_sync <= '0;
    end else begin
      rise_sync <= {rise_sync[DEPTH-2:0], rise_tgl};
      fall_sync <= {fall_sync[DEPTH-2:0], fall_tgl};
    end

  assign hit = (rise_en & (rise_sync[DEPTH-1] ^ rise_sync[DEPTH-2])) |
               (fall_en & (fall_sync[DEPTH-1] ^ fall_sync[DEPTH-2]));
endmodule

// File: rtl/ext_irq_regs.sv
`timescale 1ns/1ps
module ext_irq_regs
  import ext_irq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [NUM_LINES-1:0]           edge_hit,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NUM_LINES-1:0]           mask_q,
  output logic [NUM_LINES-1:0]           rise_q,
  output logic [NUM_LINES-1:0]           fall_q,
  output logic [NUM_LINES-1:0]           pend_q,
  output logic [PINS_PER_PORT*SEL_W-1:0] sel_q,
  output logic [NUM_LINES-1:0]           sw_set,
  output logic [NUM_LINES-1:0]           clr_bits
);
  localparam int SEL_BASE = int'(ADDR_SEL_LO);

  logic unused_hi_bits;
  assign unused_hi_bits = ^wr_data[DATA_W-1:SEL_REG_BITS];

  assign sw_set   = (wr_en && wr_addr == ADDR_SWTRIG) ? wr_data[NUM_LINES-1:0] : '0;
  assign clr_bits = (wr_en && wr_addr == ADDR_PEND)   ? wr_data[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pend_q <= '0;
      sel_q  <= '0;
    end else begin
      pend_q <= pend_next(pend_q, clr_bits, edge_hit | sw_set);
      if (wr_en && wr_addr == ADDR_LINE_EN) mask_q <= wr_data[NUM_LINES-1:0];
      if (wr_en && wr_addr == ADDR_RISE)    rise_q <= wr_data[NUM_LINES-1:0];
      if (wr_en && wr_addr == ADDR_FALL)    fall_q <= wr_data[NUM_LINES-1:0];
      for (int k = 0; k < NUM_SEL_REGS; k++)
        if (wr_en && wr_addr == ADDR_W'(SEL_BASE + k))
          sel_q[k*SEL_REG_BITS +: SEL_REG_BITS] <= wr_data[SEL_REG_BITS-1:0];
    end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_LINE_EN: rd_data = DATA_W'(mask_q);
      ADDR_RISE:    rd_data = DATA_W'(rise_q);
      ADDR_FALL:    rd_data = DATA_W'(fall_q);
      ADDR_PEND:    rd_data = DATA_W'(pend_q);
      default:      rd_data = '0;
    endcase
    for (int k = 0; k < NUM_SEL_REGS; k++)
      if (rd_addr == ADDR_W'(SEL_BASE + k))
        rd_data = DATA_W'(sel_q[k*SEL_REG_BITS +: SEL_REG_BITS]);
  end
endmodule

// File: rtl/ext_edge_irq_ctrl.sv
`timescale 1ns/1ps
module ext_edge_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PIN_BITS-1:0]    port_pins,
  input  logic [NUM_INT_EVT-1:0] evt_in,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NUM_LINES-1:0]   irq_vec,
  output logic                   irq_any
);
  // Named internal events, visible to the bound checker.
  logic [NUM_LINES-1:0]           lines;
  logic [NUM_LINES-1:0]           edge_hit;
  logic [NUM_LINES-1:0]           sw_set;
  logic [NUM_LINES-1:0]           clr_bits;
  logic [NUM_LINES-1:0]           pend_q, mask_q, rise_q, fall_q;
  logic [PINS_PER_PORT*SEL_W-1:0] sel_q;

  ext_irq_line_router u_router (
    .port_pins (port_pins),
    .sel_flat  (sel_q),
    .evt_in    (evt_in),
    .lines     (lines)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cap
    ext_irq_edge_capture u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (lines[i]),
      .rise_en (rise_q[i]),
      .fall_en (fall_q[i]),
      .hit     (edge_hit[i])
    );
  end

  ext_irq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .edge_hit (edge_hit),
    .rd_data  (rd_data),
    .mask_q   (mask_q),
    .rise_q   (rise_q),
    .fall_q   (fall_q),
    .pend_q   (pend_q),
    .sel_q    (sel_q),
    .sw_set   (sw_set),
    .clr_bits (clr_bits)
  );

  assign irq_vec = pend_q & mask_q;
  assign irq_any = |irq_vec;
endmodule

// File: rtl/ext_irq_checker.sv
`timescale 1ns/1ps
module ext_irq_checker
  import ext_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] sw_set,
  input logic [NUM_LINES-1:0] clr_bits,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] rise_q,
  input logic [NUM_LINES-1:0] fall_q,
  input logic [NUM_LINES-1:0] irq_vec,
  input logic                 irq_any
);
  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit))); // R2
  AST_NO_HIT_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~(rise_q | fall_q)) == '0)); // R5
  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(edge_hit | sw_set)) == '0)); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits & ~edge_hit & ~sw_set) != '0) |=>
      ((pend_q & $past(clr_bits & ~edge_hit & ~sw_set)) == '0)); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits & edge_hit) != '0) |=>
      ((pend_q & $past(clr_bits & edge_hit)) == $past(clr_bits & edge_hit))); // R8
  AST_SW_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((pend_q & $past(sw_set)) == $past(sw_set))); // R9
  AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_vec & ~mask_q) == '0)); // R7
  AST_ANY_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((pend_q & mask_q) != '0)); // R7
endmodule

bind ext_edge_irq_ctrl ext_irq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_hit (edge_hit),
  .sw_set   (sw_set),
  .clr_bits (clr_bits),
  .pend_q   (pend_q),
  .mask_q   (mask_q),
  .rise_q   (rise_q),
  .fall_q   (fall_q),
  .irq_vec  (irq_vec),
  .irq_any  (irq_any)
);

// File: tb/tb_ext_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_edge_irq_ctrl;
  import ext_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [79:0] pins;
  logic [2:0]  evt;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [18:0] irq_vec;
  logic        irq_any;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;
  logic [2:0] bsel [16];

  always #2 clk = ~clk;

  ext_edge_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .port_pins(pins), .evt_in(evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_vec(irq_vec), .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.2;
    d = rd_data;
  endtask

  task automatic check_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic clear_all();
    wr(ADDR_PEND, 32'h0007_FFFF);
  endtask

  // Select word k packs fields of lines 8k..8k+7, 3 bits each, line 8k lowest.
  function automatic logic [31:0] sel_word(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[3*j +: 3] = bsel[8*k + j];
    return w;
  endfunction

  function automatic logic bline(input int n);
    if (n >= 16) return evt[n-16];
    if (bsel[n] <= 3'd4) return pins[16*int'(bsel[n]) + n];
    return 1'b0;
  endfunction

  function automatic logic [18:0] all_lines();
    logic [18:0] v;
    for (int n = 0; n < 19; n++) v[n] = bline(n);
    return v;
  endfunction

  function automatic logic [18:0] expect_hits(input logic [18:0] o, input logic [18:0] n,
                                              input logic [18:0] r, input logic [18:0] f);
    return ((~o & n) & r) | ((o & ~n) & f);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) bsel[i] = 3'd0;
    pins = '0; evt = '0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 0;
    negs(3);
    rst_n = 1;
    negs(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) check_reg("R1 reset register", 3'(a), 32'h0);
    check("R1 irq_vec reset", 32'(irq_vec), 32'h0);
    check("R1 irq_any reset", 32'(irq_any), 32'h0);

    // R2 rising edge on line 3 (port 0 bit 3), latency of three clock edges
    wr(ADDR_RISE, 32'h8);
    pins[3] = 1'b1;
    negs(2);
    check_reg("R2 pending before third edge", ADDR_PEND, 32'h0);
    negs(1);
    check_reg("R2 pending on third edge", ADDR_PEND, 32'h8);
    clear_all();
    pins[3] = 1'b0;
    negs(4);
    check_reg("R2 falling ignored with rise only", ADDR_PEND, 32'h0);

    // R3 falling edge on line 5 routed from port 2
    bsel[5] = 3'd2;
    wr(ADDR_SEL_LO, sel_word(0));
    wr(ADDR_FALL, 32'h20);
    pins[37] = 1'b1;
    negs(4);
    check_reg("R3 rising ignored with fall only", ADDR_PEND, 32'h0);
    pins[37] = 1'b0;
    negs(3);
    check_reg("R3 falling sets pending", ADDR_PEND, 32'h20);
    clear_all();

    // R4 and R11 both edges on line 16 from evt_in[0], rise on 18 from evt_in[2]
    wr(ADDR_RISE, 32'h5_0000);
    wr(ADDR_FALL, 32'h1_0000);
    evt[0] = 1'b1;
    negs(3);
    check_reg("R4 R11 rise on event line 16", ADDR_PEND, 32'h1_0000);
    clear_all();
    evt[0] = 1'b0;
    negs(3);
    check_reg("R4 fall on event line 16", ADDR_PEND, 32'h1_0000);
    clear_all();
    evt[2] = 1'b1; evt[1] = 1'b1;
    negs(4);
    check_reg("R11 event line 18 only, 17 disabled", ADDR_PEND, 32'h4_0000);
    clear_all();
    evt = '0;
    negs(4);
    clear_all();

    // R6 narrow pulses inside one low clock phase
    wr(ADDR_RISE, 32'h200);
    wr(ADDR_FALL, 32'h400);
    @(negedge clk);
    #0.5 pins[9] = 1'b1;
    #0.5 pins[9] = 1'b0;
    #0.3 pins[10] = 1'b1;
    #0.3 pins[10] = 1'b0;
    negs(4);
    check_reg("R6 narrow pulses caught on both polarities", ADDR_PEND, 32'h600);
    clear_all();

    // R7 mask behaviour
    wr(ADDR_RISE, 32'h0);
    wr(ADDR_FALL, 32'h0);
    wr(ADDR_SWTRIG, 32'h8);
    check("R7 masked irq_vec", 32'(irq_vec), 32'h0);
    check("R7 masked irq_any", 32'(irq_any), 32'h0);
    check_reg("R7 masked line keeps pending", ADDR_PEND, 32'h8);
    wr(ADDR_LINE_EN, 32'h8);
    check("R7 enabled irq_vec", 32'(irq_vec), 32'h8);
    check("R7 enabled irq_any", 32'(irq_any), 32'h1);
    wr(ADDR_LINE_EN, 32'h0);
    check("R7 re-masked irq_any", 32'(irq_any), 32'h0);

    // R8 write-one-to-clear
    wr(ADDR_PEND, 32'h0);
    check_reg("R8 write zero no effect", ADDR_PEND, 32'h8);
    wr(ADDR_PEND, 32'h10);
    check_reg("R8 clear of other bit no effect", ADDR_PEND, 32'h8);
    wr(ADDR_RISE, 32'h8);
    pins[3] = 1'b1;
    negs(2);
    wr_en = 1'b1; wr_addr = ADDR_PEND; wr_data = 32'h8;
    negs(1);
    wr_en = 1'b0;
    check_reg("R8 edge in clear cycle keeps bit", ADDR_PEND, 32'h8);
    wr(ADDR_PEND, 32'h8);
    check_reg("R8 clear removes bit", ADDR_PEND, 32'h0);

    // R9 software trigger
    wr(ADDR_RISE, 32'h0);
    wr(ADDR_SWTRIG, 32'h2_1000);
    check_reg("R9 software trigger sets lines 12 and 17", ADDR_PEND, 32'h2_1000);
    check_reg("R9 trigger register reads zero", ADDR_SWTRIG, 32'h0);
    clear_all();

    // R10 port select and out-of-range select
    pins = '0;
    bsel[0] = 3'd6; bsel[15] = 3'd4;
    wr(ADDR_SEL_LO, sel_word(0));
    wr(ADDR_SEL_HI, sel_word(1));
    check_reg("R12 select low readback", ADDR_SEL_LO, sel_word(0));
    check_reg("R12 select high readback", ADDR_SEL_HI, sel_word(1));
    wr(ADDR_RISE, 32'h8001);
    negs(4);
    clear_all();
    pins[0] = 1; pins[16] = 1; pins[32] = 1; pins[48] = 1; pins[64] = 1;
    negs(4);
    check_reg("R10 select 6 holds line 0 low", ADDR_PEND, 32'h0);
    pins[79] = 1'b1;
    negs(3);
    check_reg("R10 line 15 follows port 4", ADDR_PEND, 32'h8000);
    clear_all();
    pins[15] = 1'b1;
    negs(4);
    check_reg("R10 unselected port ignored", ADDR_PEND, 32'h0);

    // R12 readback
    wr(ADDR_LINE_EN, 32'h5_A5A5);
    wr(ADDR_FALL, 32'h2_0F0F);
    check_reg("R12 enable readback", ADDR_LINE_EN, 32'h5_A5A5);
    check_reg("R12 rise readback", ADDR_RISE, 32'h8001);
    check_reg("R12 fall readback", ADDR_FALL, 32'h2_0F0F);

    // Random rounds: R2 R3 R4 R7 R10 R11
    for (int it = 0; it < 40; it++) begin
      logic [18:0] r, f, m, oldl, exp;
      r = 19'($urandom); f = 19'($urandom); m = 19'($urandom);
      for (int i = 0; i < 16; i++) bsel[i] = 3'($urandom);
      wr(ADDR_RISE, 32'(r));
      wr(ADDR_FALL, 32'(f));
      wr(ADDR_LINE_EN, 32'(m));
      wr(ADDR_SEL_LO, sel_word(0));
      wr(ADDR_SEL_HI, sel_word(1));
      negs(4);
      clear_all();
      oldl = all_lines();
      pins = pins ^ {16'($urandom), $urandom, $urandom};
      evt  = evt ^ 3'($urandom);
      exp  = expect_hits(oldl, all_lines(), r, f);
      negs(4);
      check_reg("R2 R3 R4 R10 R11 random pending", ADDR_PEND, 32'(exp));
      check("R7 random irq_vec", 32'(irq_vec), 32'(exp & m));
      check("R7 random irq_any", 32'(irq_any), 32'((exp & m) != 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule